// File: doc/BRIEF.md
# Staggered Bank Output Transition Controller

This block lives inside one column driver. It decides the clock cycle in which each bank of analog outputs takes the next line's held data. The outputs are split into banks. Every output in a bank switches together. Each bank switches later than the bank nearer the row driver, so the column transitions follow the falling select edge as it travels along the row line. A line-start strobe launches each sequence. Two programmed values, held in a small register-write port, shape the timing. The first is an initial wait in link clock cycles. The second is a per-bank step in link clock cycles.

When a driver sits further along the row, it is given a start offset equal to the full bank spread of the driver before it. The start field is therefore sized to hold the bank count times the largest step. With a step of zero, all banks switch on one cycle, which gives the conventional simultaneous transition. A strobe that arrives before the sequence has finished flushes the banks still waiting and then starts over.

The sequencer is a three-state machine:
- `ST_IDLE`: waits for a strobe.
- `ST_WAIT`: counts down the start offset.
- `ST_STEP`: counts down the step between banks.

Its transitions are:
- strobe: from any state, into `ST_WAIT`, or straight into firing when the offset is zero.
- offset expired: from `ST_WAIT`, fires bank 0 and goes to `ST_STEP`, or to `ST_IDLE` when the step is zero.
- step expired: from `ST_STEP`, fires the current bank and goes to the next one, or to `ST_IDLE` after the last bank.

Top module: `bank_stagger_ctrl`

## Requirements
- R1: While `rst_n` is low, and after reset until the first strobe, `bank_le` is all zero and `seq_done` is low, even if `line_strobe` toggles during reset.
- R2: Let E be the clock edge that samples `line_strobe` high, and let S be the start offset. `bank_le[0]` is high during the single cycle that follows edge E+S. With S = 0, this is the cycle right after the strobe.
- R3: Let T be the step. Bank k pulses in the cycle that follows edge E+S+k·T.
- R4: Bit k of `bank_le` belongs to physical bank k. Bank 0 is nearest the row driver, and banks fire in ascending index order.
- R5: In an uninterrupted sequence, each bank's latch-enable is a one-cycle pulse issued exactly once.
- R6: With T = 0, all banks pulse in the same cycle, the one after edge E+S.
- R7: S and T are captured at the strobe. A register write made during a sequence does not alter it, and takes effect from the next strobe.
- R8: A strobe at edge E2, arriving before the last bank has fired, pulses every not-yet-fired bank in the cycle after E2. The new sequence then runs from E2.
- R9: `seq_done` is high for exactly the one cycle after the cycle in which the last bank pulses.
- R10: Register writes follow this encoding:
  - `cfg_sel` = 0 writes S from the full `cfg_wdata`.
  - `cfg_sel` = 1 writes T from the low STEP_W bits.
  - S is STEP_W + log2(NUM_BANKS) bits wide, so NUM_BANKS times the largest step is reachable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_strobe | input | 1 | Line-start strobe, one cycle |
| cfg_we | input | 1 | Register write enable |
| cfg_sel | input | 1 | 0 selects start offset, 1 selects step |
| cfg_wdata | input | STEP_W+log2(NUM_BANKS) | Write data |
| bank_le | output | NUM_BANKS | Per-bank latch-enable pulses, bit 0 nearest the row driver |
| seq_done | output | 1 | One-cycle pulse after the last bank fires |

## Verification
The bench uses the default build: eight banks and a 4-bit step, which gives a 7-bit start offset. With these values the maximum offset of 120 together with the maximum step of 15 can be reached, and a whole spread takes only about 230 cycles. Random gaps between strobes are drawn shorter and longer than the spread, so both aborting strobes and fully completed sequences occur often. Directed cases cover:
- zero offset
- zero step
- writes made in mid-sequence

// File: rtl/bstg_pkg.sv
package bstg_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_STEP = 2'd2
    } seq_state_e;
endpackage

// File: rtl/bstg_cfg_regs.sv
module bstg_cfg_regs #(
    parameter int STEP_W = 4,
    parameter int OFS_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [OFS_W-1:0]  cfg_wdata,
    output logic [OFS_W-1:0]  sh_start,
    output logic [STEP_W-1:0] sh_step
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_start <= '0;
            sh_step  <= '0;
        end else if (cfg_we) begin
            if (cfg_sel) sh_step  <= cfg_wdata[STEP_W-1:0];
            else         sh_start <= cfg_wdata;
        end
    end

    // R10
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> ($stable(sh_start) && $stable(sh_step)));
endmodule

// File: rtl/bstg_seq_fsm.sv
module bstg_seq_fsm
    import bstg_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int STEP_W    = 4,
    parameter int OFS_W     = 7,
    parameter int IDX_W     = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 line_strobe,
    input  logic [OFS_W-1:0]     sh_start,
    input  logic [STEP_W-1:0]    sh_step,
    output logic [NUM_BANKS-1:0] fire
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_BANKS - 1);

    seq_state_e        st_q, st_n;
    logic [OFS_W-1:0]  cnt_q, cnt_n;
    logic [IDX_W-1:0]  idx_q, idx_n;
    logic [STEP_W-1:0] step_q, step_n;

    logic              do_launch;
    logic [IDX_W-1:0]  l_idx;
    logic [STEP_W-1:0] l_step;

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            cnt_q  <= '0;
            idx_q  <= '0;
            step_q <= '0;
        end else begin
            st_q   <= st_n;
            cnt_q  <= cnt_n;
            idx_q  <= idx_n;
            step_q <= step_n;
        end
    end

    // next-state and fire decision
    always_comb begin
        st_n      = st_q;
        cnt_n     = cnt_q;
        idx_n     = idx_q;
        step_n    = step_q;
        fire      = '0;
        do_launch = 1'b0;
        l_idx     = idx_q;
        l_step    = step_q;

        if (line_strobe) begin
            if (st_q != ST_IDLE) begin
                for (int b = 0; b < NUM_BANKS; b++) begin
                    if (IDX_W'(b) >= idx_q) fire[b] = 1'b1;
                end
            end
            step_n = sh_step;
            if (sh_start == '0) begin
                do_launch = 1'b1;
                l_idx     = '0;
                l_step    = sh_step;
            end else begin
                st_n  = ST_WAIT;
                cnt_n = sh_start - OFS_W'(1);
                idx_n = '0;
            end
        end else begin
            unique case (st_q)
                ST_IDLE: ;
                ST_WAIT: begin
                    if (cnt_q == '0) begin
                        do_launch = 1'b1;
                        l_idx     = '0;
                    end else begin
                        cnt_n = cnt_q - OFS_W'(1);
                    end
                end
                ST_STEP: begin
                    if (cnt_q == '0) do_launch = 1'b1;
                    else             cnt_n = cnt_q - OFS_W'(1);
                end
                default: st_n = ST_IDLE;
            endcase
        end

        if (do_launch) begin
            if (l_step == '0) begin
                for (int b = 0; b < NUM_BANKS; b++) begin
                    if (IDX_W'(b) >= l_idx) fire[b] = 1'b1;
                end
                st_n  = ST_IDLE;
                idx_n = l_idx;
            end else begin
                fire[l_idx] = 1'b1;
                if (l_idx == LAST_IDX) begin
                    st_n  = ST_IDLE;
                    idx_n = l_idx;
                end else begin
                    st_n  = ST_STEP;
                    idx_n = l_idx + IDX_W'(1);
                    cnt_n = OFS_W'(l_step) - OFS_W'(1);
                end
            end
        end
    end

    // R4
    bank_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_STEP && !line_strobe) |=> (idx_q >= $past(idx_q)));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && !line_strobe) |-> (fire == '0));

    // R5
    single_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_strobe && step_q != '0) |-> ($countones(fire) <= 1));
endmodule

// File: rtl/bstg_out_stage.sv
module bstg_out_stage #(
    parameter int NUM_BANKS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_BANKS-1:0] fire,
    output logic [NUM_BANKS-1:0] bank_le,
    output logic                 seq_done
);
    // output process: one flop per bank
    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_le
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) bank_le[g] <= 1'b0;
            else        bank_le[g] <= fire[g];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_done <= 1'b0;
        else        seq_done <= bank_le[NUM_BANKS-1];
    end

    // R1
    always @(posedge clk) begin
        if (!rst_n) begin
            rst_quiet_chk: assert (bank_le == '0 && !seq_done);
        end
    end

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_done && !bank_le[NUM_BANKS-1]) |=> !seq_done);
endmodule

// File: rtl/bank_stagger_ctrl.sv
module bank_stagger_ctrl #(
    parameter int NUM_BANKS = 8,
    parameter int STEP_W    = 4,
    localparam int IDX_W    = $clog2(NUM_BANKS),
    localparam int OFS_W    = STEP_W + IDX_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 line_strobe,
    input  logic                 cfg_we,
    input  logic                 cfg_sel,
    input  logic [OFS_W-1:0]     cfg_wdata,
    output logic [NUM_BANKS-1:0] bank_le,
    output logic                 seq_done
);
    logic [OFS_W-1:0]     sh_start;
    logic [STEP_W-1:0]    sh_step;
    logic [NUM_BANKS-1:0] fire;

    bstg_cfg_regs #(.STEP_W(STEP_W), .OFS_W(OFS_W)) cfg_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .sh_start(sh_start), .sh_step(sh_step)
    );

    bstg_seq_fsm #(.NUM_BANKS(NUM_BANKS), .STEP_W(STEP_W), .OFS_W(OFS_W),
                   .IDX_W(IDX_W)) fsm_i (
        .clk(clk), .rst_n(rst_n), .line_strobe(line_strobe),
        .sh_start(sh_start), .sh_step(sh_step), .fire(fire)
    );

    bstg_out_stage #(.NUM_BANKS(NUM_BANKS)) out_i (
        .clk(clk), .rst_n(rst_n), .fire(fire),
        .bank_le(bank_le), .seq_done(seq_done)
    );
endmodule

// File: tb/bank_stagger_ctrl_tb_top.sv
`timescale 1ns/1ps
module bank_stagger_ctrl_tb_top;
    localparam int NB    = 8;
    localparam int SW    = 4;
    localparam int OW    = 7;
    localparam int SMASK = (1 << SW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          line_strobe = 1'b0;
    logic          cfg_we = 1'b0;
    logic          cfg_sel = 1'b0;
    logic [OW-1:0] cfg_wdata = '0;
    logic [NB-1:0] bank_le;
    logic          seq_done;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit mon_en = 1'b0;
    bit finished = 1'b0;
    string cur_req = "R1";

    int m_start = 0;
    int m_step = 0;
    int pend[NB];
    int flush_at = -1;
    logic [NB-1:0] flush_mask = '0;
    logic prev_exp_last = 1'b0;

    always #2.5 clk = ~clk;

    bank_stagger_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .line_strobe(line_strobe),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .bank_le(bank_le), .seq_done(seq_done)
    );

    function automatic int bank_time(int c, int s, int t, int k);
        return c + s + k * t;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s cyc=%0d actual=%0h expected=%0h", req, cyc, act, exp);
        end
    endtask

    always @(posedge clk) begin
        logic [NB-1:0] exp_le;
        cyc++;
        #1;
        if (mon_en) begin
            exp_le = '0;
            for (int k = 0; k < NB; k++) begin
                if (pend[k] == cyc) begin
                    exp_le[k] = 1'b1;
                    pend[k] = -1;
                end
            end
            if (flush_at == cyc) exp_le |= flush_mask;
            check({cur_req, " bank_le"}, 32'(bank_le), 32'(exp_le));
            check({"R9 via ", cur_req}, 32'(seq_done), 32'(prev_exp_last));
            prev_exp_last = exp_le[NB-1];
        end
    end

    task automatic cfg_write(bit sel, int val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = OW'(val);
        @(negedge clk);
        cfg_we = 1'b0;
        if (sel) m_step = val & SMASK;
        else     m_start = val;
    endtask

    task automatic fire_line();
        int c;
        @(negedge clk);
        c = cyc + 1;
        flush_mask = '0;
        for (int k = 0; k < NB; k++) begin
            if (pend[k] >= c) flush_mask[k] = 1'b1;
        end
        flush_at = c;
        for (int k = 0; k < NB; k++) pend[k] = bank_time(c, m_start, m_step, k);
        line_strobe = 1'b1;
        @(negedge clk);
        line_strobe = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic run_line(int s, int t, int gap);
        cfg_write(1'b0, s);
        cfg_write(1'b1, t);
        fire_line();
        idle(gap);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240607));
        for (int k = 0; k < NB; k++) pend[k] = -1;

        // R1: reset holds everything quiet even with strobes
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            line_strobe = i[0];
            check("R1 le in reset", 32'(bank_le), 32'h0);
            check("R1 done in reset", 32'(seq_done), 32'h0);
        end
        @(negedge clk);
        line_strobe = 1'b0;
        rst_n = 1'b1;
        mon_en = 1'b1;
        cur_req = "R1";
        idle(20);

        // R2: zero offset fires bank 0 right after strobe
        cur_req = "R2";
        run_line(0, 3, 40);
        run_line(6, 2, 40);

        // R3 / R4: staggered banks in physical order
        cur_req = "R3";
        run_line(4, 5, 60);
        cur_req = "R4";
        run_line(1, 1, 20);

        // R5: pulses are single cycle
        cur_req = "R5";
        run_line(2, 7, 70);

        // R6: zero step gives simultaneous transition
        cur_req = "R6";
        run_line(3, 0, 15);
        run_line(0, 0, 10);

        // R7: mid-sequence writes take effect at the next strobe
        cur_req = "R7";
        cfg_write(1'b0, 10);
        cfg_write(1'b1, 5);
        fire_line();
        idle(3);
        cfg_write(1'b0, 0);
        cfg_write(1'b1, 1);
        idle(60);
        fire_line();
        idle(20);

        // R8: aborting strobe flushes remaining banks
        cur_req = "R8";
        run_line(2, 10, 25);
        run_line(0, 4, 40);
        run_line(9, 3, 5);
        run_line(0, 0, 12);

        // R10: maximum offset and step, step taken from low bits
        cur_req = "R10";
        run_line(120, 15, 240);
        cfg_write(1'b1, 8'h7F & 8'h73);
        cfg_write(1'b0, 0);
        fire_line();
        idle(30);

        // random mix
        cur_req = "R3";
        for (int i = 0; i < 40; i++) begin
            int s, t, g;
            s = $urandom_range(0, 120);
            t = $urandom_range(0, 15);
            g = $urandom_range(1, s + 7 * t + 20);
            run_line(s, t, g);
        end
        idle(260);

        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule